// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block is the page-program engine that sits behind a two-wire serial memory slave controller. The controller hands it one data byte at a time. The first byte of a transaction also supplies the target address. The engine stores each byte in a 32-entry page buffer, indexed by the low five address bits. After each byte that index advances by one and wraps inside the page. The upper address bits are frozen at the first byte.

A stop strobe commits the buffer to the backing array. Only the entries that were actually written are sent over the array write port, one entry per clock and in ascending index order. The engine then reports busy for a fixed, parameterised number of system clock ticks before it returns to standby.

While the engine is busy it ignores all strobes. An abort strobe throws the buffered data away. The write-protect level is captured at the first byte of a transaction, and if it was high the stop discards the buffer instead of programming the array.

Top module: `page_write_engine`

## Requirements
- R1: After a synchronous reset, `busy` and `mem_we` are low and the page buffer is empty.
- R2: The first accepted byte of a transaction fixes the page (address bits 10:5) and the starting index (bits 4:0). `byte_addr` on later bytes is ignored. Each later byte goes to the previous index plus one, modulo 32, in the same page.
- R3: When more bytes arrive than fit before the index wraps, the later byte replaces the earlier one at the same index. The array receives only the last value written to each index.
- R4: Any count from 1 to 32 distinct entries may be committed in one cycle. Exactly one array write is issued per written entry, and every other location of the page keeps its old contents.
- R5: Programming starts only on a stop strobe that follows at least one accepted byte. A stop with an empty buffer leaves `busy` low.
- R6: `busy` rises in the cycle after an accepted stop and stays high for exactly `CYCLE_TICKS` clock cycles (at least 32).
- R7: While `busy` is high, byte, stop and abort strobes have no effect. Nothing offered during the cycle is captured, and the cycle length is unchanged.
- R8: The `wp_in` level at the first accepted byte governs the whole transaction. If it was high, the stop issues no array writes and does not raise `busy`. Later changes of `wp_in` within the transaction have no effect.
- R9: An abort strobe while idle empties the buffer with no array write. A following stop then does nothing.
- R10: Array writes (`mem_we` high) occur only while `busy` is high, within its first 32 cycles, and with strictly ascending index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe: a data byte is offered |
| byte_addr | input | ADDR_W | Target address; used only on the first byte of a transaction |
| byte_data | input | 8 | Data byte |
| stop_pls | input | 1 | One-cycle strobe: stop condition seen, commit the buffer |
| abort_pls | input | 1 | One-cycle strobe: transaction abandoned, discard the buffer |
| wp_in | input | 1 | Write-protect level, high blocks programming |
| busy | output | 1 | High during the timed write cycle |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
A wrong index pointer or page register shows up at the array port during the sweep that follows the next stop. The byte lands at the wrong address within 32 cycles of that stop, so the bench compares the complete array image after every cycle. A stale or leaking valid mask shows up as an extra or missing write in that same sweep, or as a cycle that starts when it should not. Counting writes and busy cycles exposes it as soon as the transaction ends. A latched protect level that is wrong or latched at the wrong time shows up immediately at the stop, because `busy` must or must not rise in the next cycle.

// File: rtl/pwe_pkg.sv
package pwe_pkg;

    typedef logic [7:0] pw_byte_t;

    typedef enum logic {
        PH_STANDBY = 1'b0,
        PH_PROGRAM = 1'b1
    } pw_phase_e;

    // The cycle must be long enough to sweep every buffer entry.
    function automatic int eff_ticks(input int ticks, input int entries);
        return (ticks < entries) ? entries : ticks;
    endfunction

endpackage

// File: rtl/pwe_page_buf.sv
module pwe_page_buf
    import pwe_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pw_byte_t         wr_data,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output pw_byte_t         rd_data,
    output logic             rd_vld
);
    localparam int ENTRIES = 1 << IDX_W;

    pw_byte_t           store [ENTRIES];
    logic [ENTRIES-1:0] vmask;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                store[i] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                vmask[i] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                vmask[i] <= 1'b1;
            end
        end
    end

    assign rd_data = store[rd_idx];
    assign rd_vld  = vmask[rd_idx];

    // R9: a clear leaves no entry marked
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (vmask == '0));

    // R2: a write marks exactly the addressed entry
    p_write_marks_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> vmask[$past(wr_idx)]);

endmodule

// File: rtl/pwe_cycle_timer.sv
module pwe_cycle_timer
    import pwe_pkg::*;
#(
    parameter int CYCLE_TICKS = 2_000_000,
    parameter int IDX_W       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             sweep_on,
    output logic [IDX_W-1:0] sweep_idx,
    output logic             done
);
    localparam int ENTRIES   = 1 << IDX_W;
    localparam int TICKS_EFF = eff_ticks(CYCLE_TICKS, ENTRIES);
    localparam int CNT_W     = $clog2(TICKS_EFF) + 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TICKS_EFF - 1);
    localparam logic [CNT_W-1:0] ENT_C = CNT_W'(ENTRIES);

    pw_phase_e        phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_STANDBY;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_STANDBY: begin
                    if (start) begin
                        phase <= PH_PROGRAM;
                        cnt   <= '0;
                    end
                end
                PH_PROGRAM: begin
                    if (cnt == LAST) begin
                        phase <= PH_STANDBY;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_STANDBY;
            endcase
        end
    end

    assign busy      = (phase == PH_PROGRAM);
    assign done      = busy && (cnt == LAST);
    assign sweep_on  = busy && (cnt < ENT_C);
    assign sweep_idx = cnt[IDX_W-1:0];

    // R6: every cycle begins with the count at zero
    p_cycle_starts_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cnt == '0));

    // R7: a start during a running cycle does not end it early
    p_no_early_end_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
    import pwe_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int IDX_W       = 5,
    parameter int CYCLE_TICKS = 2_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [7:0]        byte_data,
    input  logic              stop_pls,
    input  logic              abort_pls,
    input  logic              wp_in,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int BASE_W = ADDR_W - IDX_W;

    logic              open_q;
    logic              wp_q;
    logic [BASE_W-1:0] base_q;
    logic [IDX_W-1:0]  ptr_q;

    logic             idle, take, first, ends, go, drop, clr;
    logic [IDX_W-1:0] wr_idx;
    logic             sweep_on, done, rd_vld;
    logic [IDX_W-1:0] sweep_idx;
    pw_byte_t         rd_data;

    assign idle   = !busy;
    assign take   = byte_vld && idle && !stop_pls && !abort_pls;
    assign first  = take && !open_q;
    assign wr_idx = first ? byte_addr[IDX_W-1:0] : ptr_q;
    assign ends   = idle && (stop_pls || abort_pls);
    assign go     = idle && stop_pls && !abort_pls && open_q && !wp_q;
    assign drop   = ends && !go;
    assign clr    = drop || done;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            wp_q   <= 1'b0;
            base_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (take) begin
                ptr_q  <= wr_idx + 1'b1;
                open_q <= 1'b1;
                if (first) begin
                    base_q <= byte_addr[ADDR_W-1:IDX_W];
                    wp_q   <= wp_in;
                end
            end
            if (ends) begin
                open_q <= 1'b0;
            end
        end
    end

    pwe_page_buf #(.IDX_W(IDX_W)) i_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (take),
        .wr_idx  (wr_idx),
        .wr_data (byte_data),
        .clr     (clr),
        .rd_idx  (sweep_idx),
        .rd_data (rd_data),
        .rd_vld  (rd_vld)
    );

    pwe_cycle_timer #(.CYCLE_TICKS(CYCLE_TICKS), .IDX_W(IDX_W)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (go),
        .busy      (busy),
        .sweep_on  (sweep_on),
        .sweep_idx (sweep_idx),
        .done      (done)
    );

    assign mem_we    = sweep_on && rd_vld;
    assign mem_addr  = {base_q, sweep_idx};
    assign mem_wdata = rd_data;

    // R10: the array is written only inside the timed cycle
    p_we_inside_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R5: a cycle begins only right after a stop strobe
    p_cycle_needs_stop_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_pls));

    // R8: a protected transaction never starts a cycle
    p_protect_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wp_q));

    // R2: the page stays fixed while it is being programmed
    p_page_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(base_q));

    // R7: no transaction can open while a cycle runs
    p_closed_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> !open_q);

endmodule

// File: tb/test_page_write_engine.sv
`timescale 1ns/1ps
module test_page_write_engine;
    localparam int ADDR_W = 11;
    localparam int IDX_W  = 5;
    localparam int TICKS  = 40;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic [10:0] addr;
        logic [5:0]  n;
        logic        wp;
        logic [7:0]  seed;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{11'h000, 6'd1,  1'b0, 8'h11},  // single byte
        '{11'h01E, 6'd4,  1'b0, 8'h40},  // wraps inside page 0
        '{11'h7E5, 6'd32, 1'b0, 8'h03},  // full page, last page
        '{11'h3A0, 6'd35, 1'b0, 8'h90},  // three bytes overwrite
        '{11'h140, 6'd5,  1'b1, 8'h55},  // protected
        '{11'h205, 6'd3,  1'b0, 8'hC8}   // short, mid-page start
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              byte_vld = 1'b0;
    logic [ADDR_W-1:0] byte_addr = '0;
    logic [7:0]        byte_data = '0;
    logic              stop_pls = 1'b0;
    logic              abort_pls = 1'b0;
    logic              wp_in = 1'b0;
    logic              busy, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;

    page_write_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CYCLE_TICKS(TICKS)) i_page_write_engine (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_addr(byte_addr),
        .byte_data(byte_data), .stop_pls(stop_pls), .abort_pls(abort_pls),
        .wp_in(wp_in), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int busy_cycles = 0;
    int wr_count = 0;
    int order_err = 0;
    logic       have_prev = 1'b0;
    logic [4:0] prev_idx = '0;
    logic [7:0] model [DEPTH];
    logic [7:0] expm  [DEPTH];

    // Array model: what the array would hold, plus write statistics.
    always @(negedge clk) begin
        if (busy) busy_cycles++;
        if (mem_we) begin
            model[mem_addr] = mem_wdata;
            wr_count++;
            if (have_prev && mem_addr[4:0] <= prev_idx) order_err++;
            have_prev = 1'b1;
            prev_idx  = mem_addr[4:0];
        end else if (!busy) begin
            have_prev = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        busy_cycles = 0;
        wr_count    = 0;
        order_err   = 0;
    endtask

    task automatic send_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        byte_addr = a;
        byte_data = d;
        byte_vld  = 1'b1;
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    task automatic send_stop();
        stop_pls = 1'b1;
        @(negedge clk);
        stop_pls = 1'b0;
    endtask

    task automatic send_abort();
        abort_pls = 1'b1;
        @(negedge clk);
        abort_pls = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    function automatic int mem_diff();
        int d = 0;
        for (int i = 0; i < DEPTH; i++) if (model[i] !== expm[i]) d++;
        return d;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = 8'h00;
            expm[i]  = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(mem_we == 1'b0, "R1", "mem_we in reset", mem_we, 0);
        rst = 1'b0;
        @(negedge clk);
        clear_stats();
        // R1: stop right after reset finds an empty buffer
        send_stop();
        chk(busy == 1'b0, "R1", "busy after stop on fresh buffer", busy, 0);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            vec_t t;
            int   distinct;
            t = VECS[v];
            clear_stats();
            wp_in = t.wp;
            for (int k = 0; k < int'(t.n); k++) begin
                // only the first address counts (R2)
                send_byte((k == 0) ? t.addr : (11'h7FF ^ ADDR_W'(k * 37)),
                          8'(int'(t.seed) + k * 7));
            end
            send_stop();
            chk(busy == !t.wp, "R8", "busy after stop", busy, !t.wp);
            wait_idle();
            wp_in = 1'b0;
            chk(busy_cycles == (t.wp ? 0 : TICKS), "R6", "busy cycle length",
                busy_cycles, t.wp ? 0 : TICKS);
            if (!t.wp) begin
                for (int k = 0; k < int'(t.n); k++) begin
                    logic [4:0] ix;
                    ix = 5'(int'(t.addr[4:0]) + k);
                    expm[{t.addr[10:5], ix}] = 8'(int'(t.seed) + k * 7);
                end
            end
            distinct = t.wp ? 0 : ((t.n > 32) ? 32 : int'(t.n));
            chk(wr_count == distinct, "R4", "array write count", wr_count, distinct);
            chk(mem_diff() == 0, "R3", "array image (R2 wrap)", mem_diff(), 0);
            chk(order_err == 0, "R10", "ascending write order", order_err, 0);
        end

        // R5: stop with nothing buffered
        clear_stats();
        send_stop();
        chk(busy == 1'b0, "R5", "busy after empty stop", busy, 0);

        // R9: abort discards buffered bytes
        clear_stats();
        send_byte(11'h100, 8'hA1);
        send_byte(11'h100, 8'hA2);
        send_byte(11'h100, 8'hA3);
        send_abort();
        send_stop();
        chk(busy == 1'b0, "R9", "busy after abort then stop", busy, 0);
        repeat (40) @(negedge clk);
        chk(wr_count == 0, "R9", "writes after abort", wr_count, 0);
        chk(mem_diff() == 0, "R9", "array image after abort", mem_diff(), 0);

        // R7: strobes during the cycle are ignored
        clear_stats();
        send_byte(11'h060, 8'h5A);
        send_byte(11'h060, 8'h5B);
        send_stop();
        repeat (3) @(negedge clk);
        send_byte(11'h0C0, 8'hEE);
        send_stop();
        send_abort();
        send_byte(11'h0C1, 8'hEF);
        wait_idle();
        expm[11'h060] = 8'h5A;
        expm[11'h061] = 8'h5B;
        chk(busy_cycles == TICKS, "R7", "cycle length with strobes", busy_cycles, TICKS);
        chk(wr_count == 2, "R7", "writes with strobes in cycle", wr_count, 2);
        chk(mem_diff() == 0, "R7", "array image after cycle", mem_diff(), 0);
        send_stop();
        chk(busy == 1'b0, "R7", "nothing captured during cycle", busy, 0);

        // R8: protect level latched at the first byte
        clear_stats();
        wp_in = 1'b0;
        send_byte(11'h300, 8'h71);
        wp_in = 1'b1;
        send_byte(11'h300, 8'h72);
        send_stop();
        chk(busy == 1'b1, "R8", "late protect ignored", busy, 1);
        wait_idle();
        expm[11'h300] = 8'h71;
        expm[11'h301] = 8'h72;
        chk(mem_diff() == 0, "R8", "array image late protect", mem_diff(), 0);
        clear_stats();
        wp_in = 1'b1;
        send_byte(11'h320, 8'h81);
        wp_in = 1'b0;
        send_byte(11'h320, 8'h82);
        send_stop();
        chk(busy == 1'b0, "R8", "early protect holds", busy, 0);
        repeat (40) @(negedge clk);
        chk(wr_count == 0, "R8", "writes under protect", wr_count, 0);
        chk(mem_diff() == 0, "R8", "array image under protect", mem_diff(), 0);

        summary();
        $finish;
    end
endmodule